// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address of every beat of an SDRAM burst, the way a memory device steps through columns on its own after it takes a read or write command. A start strobe loads a starting column, a burst length code and an ordering flag. From the next cycle on, the block presents one column per clock together with a beat-valid flag and a last-beat flag.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside a block of columns aligned to the burst length. Two orderings are supported. Sequential ordering counts upward and wraps. Interleaved ordering XORs the starting low bits with the beat number. There is also a full-page mode, which exists only for sequential ordering. It steps through all 512 columns, wraps from 511 to 0, and runs until a burst-stop strobe or a new start ends it. A new start is accepted on any cycle, including the cycle right after the previous start, and it replaces the burst in progress.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and after it until the first start, beat_valid_o and last_beat_o are low.
- R2: A start_i sampled at a clock edge makes beat 0 visible right after that edge: beat_valid_o is high and col_o equals start_col_i.
- R3: With ordering flag interleave_i=0 and length code 0, 1, 2 or 3 (1, 2, 4 or 8 beats), beat n carries (start mod L + n) mod L in its low log2(L) bits. The bits above them equal those of the start column.
- R4: With interleave_i=1 and length code 0 to 3, beat n carries (start mod L) XOR n in its low log2(L) bits. The bits above them are unchanged.
- R5: last_beat_o is high exactly on beat L-1 of a fixed-length burst. In the cycle after it, beat_valid_o is low unless a new start was sampled.
- R6: Length code 7 with interleave_i=0 selects full page. The column increments modulo 512, wrapping from 511 to 0. The burst stays valid until it is stopped or replaced, and last_beat_o stays low throughout.
- R7: Length code 7 with interleave_i=1 runs as an 8-beat interleaved burst.
- R8: A stop_i sampled on a valid beat, with no start in the same cycle, makes that beat the final one. beat_valid_o is low from the next cycle. This applies to fixed and full-page bursts alike.
- R9: A start sampled during a burst, including the cycle right after the previous start, abandons the old burst. The next cycle shows beat 0 of the new one.
- R10: Length codes 4, 5 and 6 are treated as a single-beat burst.
- R11: When start_i and stop_i are sampled in the same cycle, the start takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command strobe: begins a burst |
| start_col_i | input | 9 | Starting column for the burst |
| len_code_i | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 7 gives full page, 4..6 give one beat |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst-stop strobe |
| col_o | output | 9 | Column address of the current beat |
| beat_valid_o | output | 1 | A burst beat is being presented |
| last_beat_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Any corruption of the beat counter, the latched mask or the latched start column shows on col_o within one beat. The bench therefore compares every beat of every burst against a column computed independently, instead of checking only the endpoints. A wrong length mask moves the point where last_beat_o rises and where beat_valid_o drops, which shows up at most eight cycles after the start. A lost full-page flag ends a 512-column walk early or raises last_beat_o, so one complete wrap is checked beat by beat. Override and stop faults appear in the single cycle after the strobe, and that cycle is sampled directly.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

   // Beat ordering within a fixed-length burst
   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   // Number of beats for a given log2 length
   function automatic int beats_of(input int lg);
      return 1 << lg;
   endfunction

endpackage

// File: rtl/sbcg_len_decode.sv
module sbcg_len_decode
   import sbcg_pkg::*;
#(
   parameter int COL_W     = 9,
   parameter int CODE_W    = 3,
   parameter int MAX_LOG2  = 3,
   parameter int FULL_CODE = 7
) (
   input  logic [CODE_W-1:0] code_i,
   input  order_e            order_i,
   output logic [COL_W-1:0]  mask_o,
   output logic              full_o
);

   localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
   localparam logic [COL_W-1:0] MAX_MASK = ALL_ONES >> (COL_W - MAX_LOG2);

   always_comb begin
      mask_o = '0;
      full_o = 1'b0;
      for (int k = 0; k <= MAX_LOG2; k++) begin
         if (int'(code_i) == k) mask_o = ALL_ONES >> (COL_W - k);
      end
      if (int'(code_i) == FULL_CODE) begin
         if (order_i == ORD_ILV) begin
            mask_o = MAX_MASK;
         end else begin
            mask_o = ALL_ONES;
            full_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbcg_beat_ctr.sv
module sbcg_beat_ctr
   import sbcg_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   input  order_e           order_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output order_e           order_o
);

   logic final_beat;
   assign final_beat = !full_o && (beat_o == mask_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
         base_o   <= '0;
         mask_o   <= '0;
         full_o   <= 1'b0;
         order_o  <= ORD_SEQ;
      end else if (start_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
         base_o   <= base_i;
         mask_o   <= mask_i;
         full_o   <= full_i;
         order_o  <= order_i;
      end else if (active_o) begin
         if (stop_i || final_beat) begin
            active_o <= 1'b0;
         end else begin
            beat_o <= beat_o + 1'b1;
         end
      end
   end

   // R2
   start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (active_o && beat_o == '0));

   // R8
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && stop_i && !start_i) |=> !active_o);

   // R6
   full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && full_o && !stop_i && !start_i) |=> active_o);

endmodule

// File: rtl/sbcg_col_map.sv
module sbcg_col_map
   import sbcg_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  order_e           order_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;
   assign sum = base_i + beat_i;

   // Each bit inside the burst window follows the ordering; bits above stay put.
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
         if (!mask_i[b])
            col_o[b] = base_i[b];
         else if (order_i == ORD_ILV)
            col_o[b] = base_i[b] ^ beat_i[b];
         else
            col_o[b] = sum[b];
      end
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sbcg_pkg::*;
#(
   parameter int COL_W     = 9,
   parameter int CODE_W    = 3,
   parameter int MAX_LOG2  = 3,
   parameter int FULL_CODE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [CODE_W-1:0] len_code_i,
   input  logic              interleave_i,
   input  logic              stop_i,
   output logic [COL_W-1:0]  col_o,
   output logic              beat_valid_o,
   output logic              last_beat_o
);

   localparam int MAX_BEATS = beats_of(MAX_LOG2);

   if (COL_W < MAX_LOG2) begin : g_bad_width
      $error("COL_W must cover the longest fixed burst");
   end
   if (FULL_CODE <= MAX_LOG2 || FULL_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("FULL_CODE must be a free code of the length field");
   end
   if (MAX_BEATS > (1 << COL_W)) begin : g_bad_beats
      $error("burst longer than a page");
   end

   order_e           order_in;
   logic [COL_W-1:0] mask_dec;
   logic             full_dec;
   logic             active;
   logic [COL_W-1:0] beat_q, base_q, mask_q;
   logic             full_q;
   order_e           order_q;

   assign order_in = interleave_i ? ORD_ILV : ORD_SEQ;

   sbcg_len_decode #(
      .COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2), .FULL_CODE(FULL_CODE)
   ) u_dec (
      .code_i  (len_code_i),
      .order_i (order_in),
      .mask_o  (mask_dec),
      .full_o  (full_dec)
   );

   sbcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .base_i   (start_col_i),
      .mask_i   (mask_dec),
      .full_i   (full_dec),
      .order_i  (order_in),
      .active_o (active),
      .beat_o   (beat_q),
      .base_o   (base_q),
      .mask_o   (mask_q),
      .full_o   (full_q),
      .order_o  (order_q)
   );

   sbcg_col_map #(.COL_W(COL_W)) u_map (
      .base_i  (base_q),
      .beat_i  (beat_q),
      .mask_i  (mask_q),
      .order_i (order_q),
      .col_o   (col_o)
   );

   assign beat_valid_o = active;
   assign last_beat_o  = active && !full_q && (beat_q == mask_q);

   // R2
   start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

   // R5
   last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat_o && !start_i) |=> !beat_valid_o);

   // R3
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && !last_beat_o && !full_q && !start_i && !stop_i)
         |=> $stable(col_o & ~mask_q));

   // R1
   idle_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid_o |-> !last_beat_o);

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [8:0] scol = '0;
   logic [2:0] code = '0;
   logic       ilv = 1'b0;
   logic       stop = 1'b0;
   logic [8:0] col;
   logic       valid, last;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   sdram_burst_colgen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(scol),
      .len_code_i(code), .interleave_i(ilv), .stop_i(stop),
      .col_o(col), .beat_valid_o(valid), .last_beat_o(last)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int s, input int len, input bit il, input int n);
      int lo = s % len;
      int blk = s - lo;
      if (il) return blk + (lo ^ n);
      return blk + ((lo + n) % len);
   endfunction

   // Drive a start at a falling edge; return at the falling edge showing beat 0.
   task automatic launch(input int c, input int lc, input bit il);
      @(negedge clk);
      start = 1'b1; scol = 9'(c); code = 3'(lc); ilv = il;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_fixed(input string req, input int c, input int lc,
                            input bit il, input int len);
      launch(c, lc, il);
      for (int n = 0; n < len; n++) begin
         chk({req, " col"}, col, exp_col(c, len, il, n));
         chk({req, " valid"}, valid, 1);
         chk({"R5 last in ", req}, last, (n == len - 1) ? 1 : 0);
         @(negedge clk);
      end
      chk({"R5 valid after last ", req}, valid, 0);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", valid, 0);
      chk("R1 last in reset", last, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid idle", valid, 0);
      chk("R1 last idle", last, 0);
   endtask

   task automatic t_sequential;
      run_fixed("R2 R3 len1", 77, 0, 0, 1);
      run_fixed("R3 len2", 131, 1, 0, 2);
      run_fixed("R3 len4", 6, 2, 0, 4);
      run_fixed("R3 len8", 13, 3, 0, 8);
      run_fixed("R3 len8 top", 511, 3, 0, 8);
   endtask

   task automatic t_interleaved;
      run_fixed("R4 len2", 41, 1, 1, 2);
      run_fixed("R4 len4", 202, 2, 1, 4);
      run_fixed("R4 len8", 293, 3, 1, 8);
      run_fixed("R7 full code ilv", 374, 7, 1, 8);
   endtask

   task automatic t_reserved;
      run_fixed("R10 code4", 9, 4, 0, 1);
      run_fixed("R10 code6", 250, 6, 1, 1);
   endtask

   task automatic t_full_page;
      launch(508, 7, 0);
      for (int n = 0; n < 520; n++) begin
         chk("R6 full col", col, (508 + n) % 512);
         chk("R6 full valid", valid, 1);
         chk("R6 full last", last, 0);
         if (n == 519) stop = 1'b1;
         @(negedge clk);
      end
      stop = 1'b0;
      chk("R8 full stopped", valid, 0);
      chk("R8 full stopped last", last, 0);
   endtask

   task automatic t_stop_fixed;
      launch(16, 3, 0);
      chk("R8 beat0", col, 16);
      @(negedge clk);
      chk("R8 beat1", col, 17);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R8 fixed stopped", valid, 0);
      chk("R8 fixed stopped last", last, 0);
   endtask

   task automatic t_override;
      launch(5, 3, 0);
      chk("R9 first beat0", col, 5);
      @(negedge clk);
      chk("R9 first beat1", col, 6);
      start = 1'b1; scol = 9'd102; code = 3'd2; ilv = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 4; n++) begin
         chk("R9 new burst col", col, exp_col(102, 4, 1'b1, n));
         chk("R9 new burst last", last, (n == 3) ? 1 : 0);
         @(negedge clk);
      end
      chk("R9 ends", valid, 0);
      // back-to-back starts one clock apart
      launch(300, 3, 0);
      chk("R9 b2b A beat0", col, 300);
      start = 1'b1; scol = 9'd450; code = 3'd1; ilv = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk("R9 b2b B beat0", col, 450);
      @(negedge clk);
      chk("R9 b2b B beat1", col, 451);
      chk("R9 b2b B last", last, 1);
      @(negedge clk);
      chk("R9 b2b B done", valid, 0);
   endtask

   task automatic t_start_stop;
      @(negedge clk);
      start = 1'b1; stop = 1'b1; scol = 9'd60; code = 3'd2; ilv = 1'b0;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      chk("R11 valid", valid, 1);
      chk("R11 col", col, 60);
      @(negedge clk);
      chk("R11 continues", col, 61);
      repeat (3) @(negedge clk);
      chk("R11 done", valid, 0);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_sequential();
      t_interleaved();
      t_reserved();
      t_full_page();
      t_stop_fixed();
      t_override();
      t_start_stop();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule